// File: doc/BRIEF.md
# Vector Register Execution Sequencer

This block is a compact vector execution engine. It holds eight vector registers of 64 integer elements each, and it runs whole-vector instructions on two pipelined functional units: an adder and a multiplier. One instruction names a destination register, a first source register and either a second source register or a scalar. The block sends one element pair per clock into the unit that owns the operation and writes each result back to the destination register. The unit then pulses a completion flag. Integer arithmetic, wrapped to the element width, stands in for floating point.

Instructions arrive on a valid/ready handshake together with a vector length. An instruction that targets a busy unit is held. An instruction that touches a register with an outstanding write is also held. Instructions for different units may start on consecutive clocks and then run concurrently. A combinational debug port reads any element of any register. After reset the registers hold a computed pattern, so that a host can run instructions without a load path.

Top module: `vec_seq`

## Requirements
- R1: After reset, unit_busy and unit_done are 0, in_ready is 1, and element i of register r holds r*64+i+1 (modulo 2^W).
- R2: The op code selects the operation, with results taken modulo 2^W. 2'b00 gives dst[i]=a[i]+b[i] on the add unit (status bit 0). 2'b01 gives dst[i]=a[i]*b[i] on the multiply unit (status bit 1). 2'b10 and 2'b11 give dst[i]=a[i]*scalar on the multiply unit.
- R3: An instruction of length n>0 accepted at clock edge t has its unit_done bit set by edge t+L+n, with L=6 for add and L=7 for multiply. All n results are in the register by that edge.
- R4: Instructions for different units overlap. A length-64 multiply accepted at edge t and a length-64 add accepted at edge t+1 both complete at edge t+71.
- R5: A unit's busy bit is set from its acceptance edge until its completion edge. While the target unit is busy, in_ready stays low.
- R6: Each accepted instruction produces exactly one single-clock unit_done pulse. The busy bit clears on the same edge.
- R7: An instruction is held when any register it uses has a write outstanding from an earlier instruction. The registers it uses are its first source, its second source (unless the op is scalar) and its destination. It is accepted no earlier than 4 edges after that writer's completion edge, and exactly then if valid is held.
- R8: A length of 0 writes nothing. It sets unit_done on the acceptance edge and leaves the busy bit low.
- R9: Lengths above 64 run as 64. A length n writes only elements 0..n-1 and leaves the other elements of the destination unchanged.
- R10: dbg_data shows, combinationally, element dbg_idx of register dbg_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_op | input | 2 | Operation code |
| in_dst | input | 3 | Destination register |
| in_srca | input | 3 | First source register |
| in_srcb | input | 3 | Second source register (unused for scalar ops) |
| in_scalar | input | W | Scalar operand |
| in_len | input | LENW | Vector length |
| unit_busy | output | 2 | Per-unit busy, bit 0 add, bit 1 multiply |
| unit_done | output | 2 | Per-unit completion pulse |
| dbg_reg | input | 3 | Debug register select |
| dbg_idx | input | 6 | Debug element select |
| dbg_data | output | W | Debug element value |

## Verification
The bench times every completion against start-up plus length. It therefore catches a unit with the wrong latency, one that drops or repeats an element, and a length clamp that is off by one. Back-to-back multiply and add instructions confirm that the units overlap: a sequencer that serialises them finishes the add tens of clocks late. Dependent and same-destination pairs measure the acceptance edge exactly. A missing hold would read stale elements, and a wrong penalty would shift acceptance by a clock. Zero-length, partial-length and self-overlapping instructions, mixed with a random stream, expose stray writes beyond the length and read-before-write ordering errors.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;
   localparam int NUNITS = 2;
   localparam int U_ADD  = 0;
   localparam int U_MUL  = 1;

   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_MUL   = 2'b01,
      OP_SMUL  = 2'b10,
      OP_SMULX = 2'b11
   } vop_e;

   function automatic logic op_to_mul(input logic [1:0] op);
      return op != OP_ADD;
   endfunction

   function automatic logic op_is_scalar(input logic [1:0] op);
      return op[1];
   endfunction
endpackage

// File: rtl/vec_seq_rf.sv
module vec_seq_rf #(
   parameter int W    = 16,
   parameter int NREG = 8,
   parameter int NEL  = 64,
   parameter int NWP  = 2,
   parameter int NRP  = 5,
   localparam int RW  = $clog2(NREG),
   localparam int EW  = $clog2(NEL)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NWP-1:0]           we,
   input  logic [NWP-1:0][RW-1:0]   wreg,
   input  logic [NWP-1:0][EW-1:0]   widx,
   input  logic [NWP-1:0][W-1:0]    wdata,
   input  logic [NRP-1:0][RW-1:0]   rreg,
   input  logic [NRP-1:0][EW-1:0]   ridx,
   output logic [NRP-1:0][W-1:0]    rdata
);
   initial begin : elab_chk
      assert ((1 << RW) == NREG) else $fatal(1, "NREG must be a power of two");
      assert ((1 << EW) == NEL)  else $fatal(1, "NEL must be a power of two");
   end

   logic [W-1:0] mem [NREG][NEL];

   // writers never target the same register on one edge (scoreboard holds them apart)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++)
            for (int e = 0; e < NEL; e++)
               mem[r][e] <= W'(r * NEL + e + 1);
      end else begin
         for (int p = 0; p < NWP; p++)
            if (we[p]) mem[wreg[p]][widx[p]] <= wdata[p];
      end
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rd
      assign rdata[p] = mem[rreg[p]][ridx[p]];
   end
endmodule

// File: rtl/vec_seq_lane.sv
module vec_seq_lane #(
   parameter int W    = 16,
   parameter int NREG = 8,
   parameter int NEL  = 64,
   parameter int LAT  = 6,
   parameter bit MULT = 1'b0,
   localparam int RW  = $clog2(NREG),
   localparam int EW  = $clog2(NEL),
   localparam int LW  = $clog2(NEL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len,
   input  logic [RW-1:0] dst,
   input  logic [RW-1:0] srca,
   input  logic [RW-1:0] srcb,
   input  logic [W-1:0]  scalar,
   input  logic          use_s,
   output logic [RW-1:0] rd_a,
   output logic [RW-1:0] rd_b,
   output logic [EW-1:0] rd_idx,
   input  logic [W-1:0]  a_data,
   input  logic [W-1:0]  b_data,
   output logic          wr_en,
   output logic [RW-1:0] wr_reg,
   output logic [EW-1:0] wr_idx,
   output logic [W-1:0]  wr_data,
   output logic          busy,
   output logic          done,
   output logic          fin
);
   initial begin : elab_chk
      assert (LAT >= 2) else $fatal(1, "LAT must be at least 2");
   end

   logic          run, last_el, use_q;
   logic [EW-1:0] idx;
   logic [LW-1:0] len_q;
   logic [RW-1:0] dst_q, sa_q, sb_q;
   logic [W-1:0]  sc_q, opb, res;
   logic [LAT-1:0] pv, pl;
   logic [EW-1:0] pi [LAT];
   logic [W-1:0]  pd [LAT];

   assign last_el = run && ((LW'(idx) + LW'(1)) == len_q);
   assign opb     = use_q ? sc_q : b_data;

   if (MULT) begin : g_mul
      assign res = a_data * opb;
   end else begin : g_add
      assign res = a_data + opb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0; idx <= '0; len_q <= '0; use_q <= 1'b0;
         dst_q <= '0; sa_q <= '0; sb_q <= '0; sc_q <= '0;
         busy <= 1'b0; done <= 1'b0; pv <= '0; pl <= '0;
      end else begin
         done <= (start && (len == '0)) || fin;
         pv   <= {pv[LAT-2:0], run};
         pl   <= {pl[LAT-2:0], last_el};
         if (start) begin
            dst_q <= dst; sa_q <= srca; sb_q <= srcb;
            sc_q  <= scalar; use_q <= use_s; len_q <= len;
            idx   <= '0;
            run   <= (len != '0);
            busy  <= (len != '0);
         end else begin
            if (run) idx <= idx + 1'b1;
            if (last_el) run <= 1'b0;
            if (fin) busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      pd[0] <= res;
      pi[0] <= idx;
      for (int s = 1; s < LAT; s++) begin
         pd[s] <= pd[s-1];
         pi[s] <= pi[s-1];
      end
   end

   assign rd_a    = sa_q;
   assign rd_b    = sb_q;
   assign rd_idx  = idx;
   assign wr_en   = pv[LAT-1];
   assign wr_reg  = dst_q;
   assign wr_idx  = pi[LAT-1];
   assign wr_data = pd[LAT-1];
   assign fin     = pv[LAT-1] && pl[LAT-1];
endmodule

// File: rtl/vec_seq_sb.sv
module vec_seq_sb #(
   parameter int NREG = 8,
   parameter int NU   = 2,
   parameter int PEN  = 4,
   localparam int RW  = $clog2(NREG),
   localparam int HW  = $clog2(PEN + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc,
   input  logic [RW-1:0]         acc_dst,
   input  logic                  acc_nz,
   input  logic [NU-1:0]         fin,
   input  logic [NU-1:0][RW-1:0] fin_reg,
   input  logic [RW-1:0]         q_a,
   input  logic [RW-1:0]         q_b,
   input  logic                  q_b_used,
   input  logic [RW-1:0]         q_dst,
   output logic                  blocked
);
   initial begin : elab_chk
      assert (PEN >= 1) else $fatal(1, "PEN must be at least 1");
   end

   logic [NREG-1:0] pend, clr, blk;
   logic [HW-1:0]   hold [NREG];

   always_comb begin
      clr = '0;
      for (int u = 0; u < NU; u++)
         if (fin[u]) clr[fin_reg[u]] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         for (int r = 0; r < NREG; r++) hold[r] <= '0;
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (clr[r]) begin
               pend[r] <= 1'b0;
               hold[r] <= HW'(PEN - 1);
            end else begin
               if (acc && acc_nz && (acc_dst == RW'(r))) pend[r] <= 1'b1;
               if (hold[r] != '0) hold[r] <= hold[r] - 1'b1;
            end
         end
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_blk
      assign blk[r] = pend[r] || (hold[r] != '0);
   end

   assign blocked = blk[q_a] || (q_b_used && blk[q_b]) || blk[q_dst];
endmodule

// File: rtl/vec_seq.sv
module vec_seq #(
   parameter int W       = 16,
   parameter int NREG    = 8,
   parameter int NEL     = 64,
   parameter int LENW    = 8,
   parameter int ADD_LAT = 6,
   parameter int MUL_LAT = 7,
   parameter int RAW_PEN = 4,
   localparam int RW     = $clog2(NREG),
   localparam int EW     = $clog2(NEL),
   localparam int LW     = $clog2(NEL + 1),
   localparam int NU     = vec_seq_pkg::NUNITS,
   localparam int NRP    = 2 * NU + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [1:0]      in_op,
   input  logic [RW-1:0]   in_dst,
   input  logic [RW-1:0]   in_srca,
   input  logic [RW-1:0]   in_srcb,
   input  logic [W-1:0]    in_scalar,
   input  logic [LENW-1:0] in_len,
   output logic [NU-1:0]   unit_busy,
   output logic [NU-1:0]   unit_done,
   input  logic [RW-1:0]   dbg_reg,
   input  logic [EW-1:0]   dbg_idx,
   output logic [W-1:0]    dbg_data
);
   import vec_seq_pkg::*;

   initial begin : elab_chk
      assert (LENW >= LW) else $fatal(1, "LENW too narrow for NEL");
   end

   logic            sel, use_s, blocked, acc;
   logic [LW-1:0]   len_c;
   logic [NU-1:0]   we, fin;
   logic [NU-1:0][RW-1:0] wreg;
   logic [NU-1:0][EW-1:0] widx;
   logic [NU-1:0][W-1:0]  wdata;
   logic [NRP-1:0][RW-1:0] rreg;
   logic [NRP-1:0][EW-1:0] ridx;
   logic [NRP-1:0][W-1:0]  rdata;

   assign sel      = op_to_mul(in_op);
   assign use_s    = op_is_scalar(in_op);
   assign len_c    = (in_len > LENW'(NEL)) ? LW'(NEL) : LW'(in_len);
   assign in_ready = !unit_busy[sel] && !blocked;
   assign acc      = in_valid && in_ready;

   for (genvar u = 0; u < NU; u++) begin : g_unit
      logic [EW-1:0] lidx;
      vec_seq_lane #(
         .W(W), .NREG(NREG), .NEL(NEL),
         .LAT((u == U_ADD) ? ADD_LAT : MUL_LAT),
         .MULT(u != U_ADD)
      ) u_lane (
         .clk(clk), .rst_n(rst_n),
         .start(acc && (sel == 1'(u))),
         .len(len_c), .dst(in_dst), .srca(in_srca), .srcb(in_srcb),
         .scalar(in_scalar), .use_s(use_s),
         .rd_a(rreg[2*u]), .rd_b(rreg[2*u+1]), .rd_idx(lidx),
         .a_data(rdata[2*u]), .b_data(rdata[2*u+1]),
         .wr_en(we[u]), .wr_reg(wreg[u]), .wr_idx(widx[u]), .wr_data(wdata[u]),
         .busy(unit_busy[u]), .done(unit_done[u]), .fin(fin[u])
      );
      assign ridx[2*u]   = lidx;
      assign ridx[2*u+1] = lidx;
   end

   assign rreg[NRP-1] = dbg_reg;
   assign ridx[NRP-1] = dbg_idx;
   assign dbg_data    = rdata[NRP-1];

   vec_seq_rf #(.W(W), .NREG(NREG), .NEL(NEL), .NWP(NU), .NRP(NRP)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(we), .wreg(wreg), .widx(widx), .wdata(wdata),
      .rreg(rreg), .ridx(ridx), .rdata(rdata)
   );

   vec_seq_sb #(.NREG(NREG), .NU(NU), .PEN(RAW_PEN)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .acc(acc), .acc_dst(in_dst), .acc_nz(len_c != '0),
      .fin(fin), .fin_reg(wreg),
      .q_a(in_srca), .q_b(in_srcb), .q_b_used(!use_s), .q_dst(in_dst),
      .blocked(blocked)
   );
endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
   parameter int LENW = 8,
   parameter int NU   = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic [1:0]      in_op,
   input logic [LENW-1:0] in_len,
   input logic [NU-1:0]   unit_busy,
   input logic [NU-1:0]   unit_done
);
   logic tgt_mul, take;
   assign tgt_mul = (in_op != 2'b00);
   assign take    = in_valid && in_ready;

   for (genvar u = 0; u < NU; u++) begin : g_u
      AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (take && (tgt_mul == 1'(u)) && (in_len != '0)) |=> unit_busy[u]); // R5
      AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
         (take && (tgt_mul == 1'(u)) && (in_len == '0)) |=> (unit_done[u] && !unit_busy[u])); // R8
      AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(unit_busy[u]) |-> unit_done[u]); // R6
      AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         unit_done[u] |-> !unit_busy[u]); // R6
   end
endmodule

bind vec_seq vec_seq_chk #(.LENW(LENW), .NU(NU)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_op(in_op), .in_len(in_len), .unit_busy(unit_busy), .unit_done(unit_done)
);

// File: tb/vec_seq_test.sv
module vec_seq_test;
   localparam int W = 16;
   localparam int PEN = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = '0;
   logic [2:0]  in_dst = '0, in_srca = '0, in_srcb = '0;
   logic [W-1:0] in_scalar = '0;
   logic [7:0]  in_len = '0;
   logic [1:0]  unit_busy, unit_done;
   logic [2:0]  dbg_reg = '0;
   logic [5:0]  dbg_idx = '0;
   logic [W-1:0] dbg_data;

   vec_seq uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_dst(in_dst), .in_srca(in_srca), .in_srcb(in_srcb),
      .in_scalar(in_scalar), .in_len(in_len), .unit_busy(unit_busy),
      .unit_done(unit_done), .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
   );

   always #10 clk = ~clk;

   int total = 0, bad = 0, cyc = 0;
   int expq [2][$];
   int last_done [2];
   logic [W-1:0] mdl [8][64];

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;
   end

   task automatic chk(input string req, input bit ok, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int lat_of(input int u);
      return (u == 0) ? 6 : 7;
   endfunction

   function automatic logic [W-1:0] calc(input logic [1:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] s);
      logic [W-1:0] r;
      if (op == 2'b00) r = a + b;
      else if (op == 2'b01) r = a * b;
      else r = a * s;
      return r;
   endfunction

   // R3 R6: each done pulse matches one accepted instruction at the expected edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int u = 0; u < 2; u++) begin
            if (unit_done[u]) begin
               if (expq[u].size() == 0) begin
                  chk("R6", 1'b0, "unexpected done pulse", cyc, -1);
               end else begin
                  int e;
                  e = expq[u].pop_front();
                  chk("R3", cyc == e, "completion edge", cyc, e);
               end
               last_done[u] = cyc;
            end
         end
      end
   end

   // called at a negedge; returns at the negedge after the acceptance edge
   task automatic issue(input logic [1:0] op, input int dst, input int a, input int b,
                        input logic [W-1:0] s, input int len, output int acc_edge);
      int n, u;
      in_op = op; in_dst = 3'(dst); in_srca = 3'(a); in_srcb = 3'(b);
      in_scalar = s; in_len = 8'(len); in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      n = (len > 64) ? 64 : len;
      u = (op == 2'b00) ? 0 : 1;
      expq[u].push_back((n == 0) ? cyc + 1 : cyc + 1 + lat_of(u) + n);
      for (int i = 0; i < n; i++)
         mdl[dst][i] = calc(op, mdl[a][i], mdl[b][i], s);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      acc_edge = cyc;
   endtask

   task automatic drain();
      while (unit_busy != 2'b00 || expq[0].size() != 0 || expq[1].size() != 0)
         @(negedge clk);
      repeat (PEN + 1) @(negedge clk);
   endtask

   task automatic cmp_reg(input int r, input string req);
      int errs = 0, fi = 0;
      logic [W-1:0] fa = '0, fe = '0;
      for (int i = 0; i < 64; i++) begin
         dbg_reg = 3'(r); dbg_idx = 6'(i);
         #1;
         if (dbg_data !== mdl[r][i]) begin
            if (errs == 0) begin fi = i; fa = dbg_data; fe = mdl[r][i]; end
            errs++;
         end
      end
      chk(req, errs == 0, $sformatf("reg %0d elem %0d", r, fi), fa, fe);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk("WD", 1'b0, "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int t0, t1, t2;
      void'($urandom(32'h5eed_1234));
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 64; i++) mdl[r][i] = W'(r * 64 + i + 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 debug port
      chk("R1", unit_busy == 2'b00, "busy after reset", unit_busy, 0);
      chk("R1", unit_done == 2'b00, "done after reset", unit_done, 0);
      chk("R1", in_ready == 1'b1, "ready after reset", in_ready, 1);
      dbg_reg = 3'd3; dbg_idx = 6'd5; #1;
      chk("R10", dbg_data == 16'd198, "debug reg3 elem5", dbg_data, 198);
      dbg_reg = 3'd7; dbg_idx = 6'd63; #1;
      chk("R1", dbg_data == 16'd512, "reset pattern reg7 elem63", dbg_data, 512);
      @(negedge clk);

      // R2 R3 plain add
      issue(2'b00, 0, 1, 2, '0, 64, t0);
      drain();
      cmp_reg(0, "R2");

      // R4 overlap: multiply then add on the next edge
      issue(2'b01, 3, 4, 5, '0, 64, t0);
      issue(2'b00, 6, 1, 2, '0, 64, t1);
      chk("R4", t1 == t0 + 1, "add accepted next edge", t1, t0 + 1);
      drain();
      chk("R4", last_done[1] == t0 + 71, "mul completion", last_done[1], t0 + 71);
      chk("R4", last_done[0] == t0 + 71, "add completion", last_done[0], t0 + 71);
      cmp_reg(3, "R2");
      cmp_reg(6, "R2");

      // R5 busy unit holds an independent instruction
      issue(2'b10, 7, 4, 0, 16'd3, 10, t0);
      chk("R5", unit_busy[1] == 1'b1, "busy after accept", unit_busy[1], 1);
      issue(2'b01, 5, 4, 4, '0, 12, t1);
      chk("R5", t1 == t0 + 7 + 10 + 1, "second mul accept edge", t1, t0 + 18);
      drain();
      cmp_reg(7, "R2");
      cmp_reg(5, "R2");

      // R7 read-after-write penalty
      issue(2'b00, 2, 1, 1, '0, 20, t0);
      issue(2'b11, 3, 2, 6, 16'd5, 30, t1);
      chk("R7", t1 == t0 + 6 + 20 + PEN, "dependent accept edge", t1, t0 + 26 + PEN);
      drain();
      cmp_reg(3, "R7");

      // R7 pending destination
      issue(2'b00, 4, 1, 1, '0, 8, t0);
      issue(2'b01, 4, 5, 6, '0, 64, t1);
      chk("R7", t1 == t0 + 6 + 8 + PEN, "same-destination accept edge", t1, t0 + 14 + PEN);
      drain();
      cmp_reg(4, "R7");

      // R8 zero length
      issue(2'b00, 6, 1, 2, '0, 0, t0);
      chk("R8", unit_done[0] == 1'b1, "done after zero-length accept", unit_done[0], 1);
      chk("R8", unit_busy[0] == 1'b0, "busy stays low", unit_busy[0], 0);
      drain();
      cmp_reg(6, "R8");

      // R9 clamp and partial length
      issue(2'b10, 7, 1, 0, 16'd3, 200, t0);
      issue(2'b00, 0, 2, 3, '0, 5, t1);
      drain();
      chk("R9", last_done[1] == t0 + 7 + 64, "clamped completion", last_done[1], t0 + 71);
      cmp_reg(7, "R9");
      cmp_reg(0, "R9");

      // random stream, includes self-overlap and all op codes
      for (int k = 0; k < 60; k++) begin
         int sel, ln;
         sel = $urandom_range(0, 9);
         if (sel == 0) ln = 0;
         else if (sel == 1) ln = $urandom_range(65, 255);
         else ln = $urandom_range(1, 64);
         issue(2'($urandom_range(0, 3)), $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7), W'($urandom), ln, t2);
      end
      drain();
      for (int r = 0; r < 8; r++) cmp_reg(r, "R2");
      chk("R6", expq[0].size() == 0 && expq[1].size() == 0, "all completions seen",
          expq[0].size() + expq[1].size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule